// File: doc/BRIEF.md
# SDRAM Auto-Precharge Bank Tracker

This block sits on the controller side of a multi-bank synchronous DRAM whose banks allow an access to one bank while another bank's auto-precharge access is still in flight. Each clock it observes the command the controller issues: a command code, a bank number and an auto-precharge flag. From that stream it keeps a model of every bank's state. A bank can be idle, open, recovering from a write, or precharging.

A single burst engine follows the burst that currently owns the data bus. A new READ or WRITE to any bank cuts that burst short. If the cut burst carried auto precharge, its bank starts precharging on the very edge the new access is registered. With no interruption, the burst ends on its last command slot and the implicit close starts there. The engine also produces a read-data-valid strobe that is aligned to the CAS latency. It produces a DQM request as well, which tells the controller that a read beat will reach the bus two clocks from now. The controller must mask that beat if it plans a WRITE for then.

Column addresses do not affect this model, so they are not taken in. An ACTIVE to a bank that is not idle is recorded in a sticky error flag.

Top module: `sdram_ap_tracker`

## Requirements
- R1: After a synchronous active-low reset, every bank reads idle, and read_valid, dqm_req and protocol_error are all 0. Bank state codes are 0 idle, 1 open, 2 write recovery and 3 precharging. Bank b occupies bank_state[2b+1:2b].
- R2: Command codes are 0 NOP, 1 ACTIVE, 2 READ and 3 WRITE. An ACTIVE registered at an edge makes the addressed bank read 1 from that edge on.
- R3: Take a READ with auto precharge registered at edge T, followed by NOPs only. read_valid is high for the 4 cycles ending at edges T+3 through T+6. The bank reads 3 from edge T+3, which is its last burst slot.
- R4: A bank that enters precharging reads 3 for exactly T_RP cycles (3 by default) and then reads 0.
- R5: A READ or WRITE to bank m, registered while a READ with auto precharge on bank n is still within its burst, makes bank n read 3 from that same edge.
- R6: When a READ to bank m cuts a read on bank n, read_valid carries only the beats of n whose slots came before the cut. It then carries the 4 beats of m, each CAS latency (3) after its slot.
- R7: While a WRITE is presented, read_valid is 0. After the WRITE is registered, no read beat that was already in flight is reported.
- R8: dqm_req is high in the cycle ending at edge E exactly when a read beat is due to be reported valid in the cycle ending at edge E+2.
- R9: A WRITE with auto precharge that runs to completion takes its bank to state 2 from its last burst slot, for T_WR cycles (2 by default). The bank then goes to state 3 for T_RP cycles, then to 0.
- R10: An ACTIVE to a bank that is not idle sets protocol_error from the next cycle on, and it stays set until reset. An ACTIVE to an idle bank leaves it clear.
- R11: A READ without auto precharge leaves its bank open (state 1) after the burst ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_code | input | 2 | Command this cycle: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE |
| cmd_bank | input | BANK_W (2) | Bank addressed by the command |
| cmd_ap | input | 1 | Auto-precharge flag for READ and WRITE |
| bank_state | output | 2*NUM_BANKS (8) | Per-bank state code, bank b at bits [2b+1:2b] |
| read_valid | output | 1 | A read beat is on the bus in this cycle |
| dqm_req | output | 1 | A read beat will be on the bus two clocks later |
| protocol_error | output | 1 | Sticky flag: ACTIVE to a non-idle bank |

## Verification
A wrong burst position or a lost interrupt shows up at the bank_state bits on the first edge after the cut or the natural burst end. The precharge code either appears a slot early or late, or it never appears. A wrong countdown keeps the precharge or write-recovery code for one cycle too many or too few, and this is visible a few cycles later. Read-pipeline faults show as a read_valid beat that is shifted, missing or extra, which becomes visible CAS latency after the slot. dqm_req shows the same fault two cycles ahead of it.

// File: rtl/sdram_trk_pkg.sv
// Package: shared command and bank-state encodings for the bank tracker.
// Assumes a 2-bit command code with no refresh or mode-register commands.
package sdram_trk_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_ACT   = 2'd1,
        CMD_READ  = 2'd2,
        CMD_WRITE = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_OPEN   = 2'd1,
        BK_WREC   = 2'd2,
        BK_PRECH  = 2'd3
    } bank_st_e;

endpackage

// File: rtl/sdram_bank_fsm.sv
// Module: state of one bank, with a single shared down-counter for
// write recovery and precharge.
// Assumes T_RP >= 1 and T_WR >= 1. The close pulses come from the burst
// engine and are never raised in the same cycle as an open for this bank.
module sdram_bank_fsm
    import sdram_trk_pkg::*;
#(
    parameter int T_RP = 3,
    parameter int T_WR = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       open_i,
    input  logic       close_rd_i,
    input  logic       close_wr_i,
    output logic [1:0] state_o
);
    localparam int CNT_MAX = (T_RP > T_WR) ? T_RP : T_WR;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    bank_st_e         st;
    logic [CNT_W-1:0] cnt;

    // Bank transitions: open, implicit close, then countdowns back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= BK_IDLE;
            cnt <= '0;
        end else if (open_i) begin
            st  <= BK_OPEN;
            cnt <= '0;
        end else if (close_rd_i) begin
            st  <= BK_PRECH;
            cnt <= CNT_W'(T_RP - 1);
        end else if (close_wr_i) begin
            st  <= BK_WREC;
            cnt <= CNT_W'(T_WR - 1);
        end else begin
            case (st)
                BK_WREC: begin
                    if (cnt == '0) begin
                        st  <= BK_PRECH;
                        cnt <= CNT_W'(T_RP - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                BK_PRECH: begin
                    if (cnt == '0) st <= BK_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign state_o = st;

    AST_OPEN_GOES_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        open_i |=> (st == BK_OPEN)); // R2
    AST_RD_CLOSE_PRECH: assert property (@(posedge clk) disable iff (!rst_n)
        (close_rd_i && !open_i) |=> (st == BK_PRECH)); // R5
    AST_WREC_THEN_PRECH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_WREC && !open_i && !close_rd_i && !close_wr_i) |=> (st inside {BK_WREC, BK_PRECH})); // R9
    AST_PRECH_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_PRECH && !open_i && !close_rd_i && !close_wr_i) |=> (st inside {BK_PRECH, BK_IDLE})); // R4

endmodule

// File: rtl/sdram_burst_engine.sv
// Module: follows the one burst that owns the data bus. Emits a close pulse
// to the bank of an auto-precharge burst when that burst ends or is cut,
// and keeps the read-beat pipeline that drives read_valid and dqm_req.
// Assumes BURST_LEN >= 2 and CAS_LAT >= 3. Write data has zero latency.
module sdram_burst_engine
    import sdram_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   cmd_i,
    input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
    input  logic                         ap_i,
    output logic [NUM_BANKS-1:0]         close_rd_o,
    output logic [NUM_BANKS-1:0]         close_wr_o,
    output logic                         read_valid_o,
    output logic                         dqm_req_o
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int LEFT_W = $clog2(BURST_LEN);

    logic              burst_on, burst_wr, burst_ap;
    logic [BANK_W-1:0] burst_bank;
    logic [LEFT_W-1:0] left;
    logic [CAS_LAT-1:0] rd_pipe;

    logic is_rd, is_wr, new_acc, old_done, rd_slot;

    // Decode of the incoming command and end-of-burst detection.
    always_comb begin
        is_rd    = (cmd_i == CMD_READ);
        is_wr    = (cmd_i == CMD_WRITE);
        new_acc  = is_rd || is_wr;
        old_done = burst_on && (new_acc || left == LEFT_W'(1));
        rd_slot  = is_rd || (burst_on && !burst_wr && !new_acc);
    end

    // Burst ownership: a new access takes over, otherwise count slots down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_on   <= 1'b0;
            burst_wr   <= 1'b0;
            burst_ap   <= 1'b0;
            burst_bank <= '0;
            left       <= '0;
        end else if (new_acc) begin
            burst_on   <= 1'b1;
            burst_wr   <= is_wr;
            burst_ap   <= ap_i;
            burst_bank <= bank_i;
            left       <= LEFT_W'(BURST_LEN - 1);
        end else if (burst_on) begin
            if (left == LEFT_W'(1)) burst_on <= 1'b0;
            left <= left - 1'b1;
        end
    end

    // Read-beat pipeline: a WRITE drops every beat still in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_pipe <= '0;
        else if (is_wr) rd_pipe <= '0;
        else            rd_pipe <= {rd_pipe[CAS_LAT-2:0], rd_slot};
    end

    // One close pulse per bank, chosen by the direction of the ending burst.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_close
        assign close_rd_o[b] = old_done && burst_ap && !burst_wr && (burst_bank == BANK_W'(b));
        assign close_wr_o[b] = old_done && burst_ap &&  burst_wr && (burst_bank == BANK_W'(b));
    end

    assign read_valid_o = rd_pipe[CAS_LAT-1] && !is_wr;
    assign dqm_req_o    = rd_pipe[CAS_LAT-3];

    AST_ONE_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(close_rd_o | close_wr_o)); // R5
    AST_NO_VALID_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |-> !read_valid_o); // R7
    AST_DQM_BEFORE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        read_valid_o |-> $past(dqm_req_o, 2)); // R8

endmodule

// File: rtl/sdram_ap_tracker.sv
// Module: top of the bank tracker. One state machine per bank, a shared
// burst engine, and a sticky error for ACTIVE to a bank that is not idle.
// Assumes commands are already legal apart from that ACTIVE check.
module sdram_ap_tracker
    import sdram_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 3,
    parameter int T_RP      = 3,
    parameter int T_WR      = 2,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             cmd_code,
    input  logic [BANK_W-1:0]      cmd_bank,
    input  logic                   cmd_ap,
    output logic [2*NUM_BANKS-1:0] bank_state,
    output logic                   read_valid,
    output logic                   dqm_req,
    output logic                   protocol_error
);
    logic [NUM_BANKS-1:0] close_rd, close_wr;
    logic                 act_busy;

    sdram_burst_engine #(
        .NUM_BANKS (NUM_BANKS),
        .BURST_LEN (BURST_LEN),
        .CAS_LAT   (CAS_LAT)
    ) u_burst (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_i        (cmd_code),
        .bank_i       (cmd_bank),
        .ap_i         (cmd_ap),
        .close_rd_o   (close_rd),
        .close_wr_o   (close_wr),
        .read_valid_o (read_valid),
        .dqm_req_o    (dqm_req)
    );

    // One state machine per bank, opened by a matching ACTIVE.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_bank_fsm #(
            .T_RP (T_RP),
            .T_WR (T_WR)
        ) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .open_i     ((cmd_code == CMD_ACT) && (cmd_bank == BANK_W'(b))),
            .close_rd_i (close_rd[b]),
            .close_wr_i (close_wr[b]),
            .state_o    (bank_state[2*b +: 2])
        );
    end

    // Detect an ACTIVE that targets a bank not currently idle.
    always_comb begin
        act_busy = (cmd_code == CMD_ACT) && (bank_state[{cmd_bank, 1'b0} +: 2] != BK_IDLE);
    end

    // Sticky error flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        protocol_error <= 1'b0;
        else if (act_busy) protocol_error <= 1'b1;
    end

    AST_ERR_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        protocol_error |=> protocol_error); // R10
    AST_ERR_ON_BUSY_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        act_busy |=> protocol_error); // R10

endmodule

// File: tb/sdram_ap_tracker_bench.sv
module sdram_ap_tracker_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd_code = 2'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic       cmd_ap = 1'b0;
    logic [7:0] bank_state;
    logic       read_valid, dqm_req, protocol_error;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sdram_ap_tracker u_sdram_ap_tracker (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_code       (cmd_code),
        .cmd_bank       (cmd_bank),
        .cmd_ap         (cmd_ap),
        .bank_state     (bank_state),
        .read_valid     (read_valid),
        .dqm_req        (dqm_req),
        .protocol_error (protocol_error)
    );

    localparam logic [1:0] NOP = 2'd0, ACT = 2'd1, RD = 2'd2, WR = 2'd3;

    // Row: {req, cmd, bank, ap, expected read_valid, expected dqm_req, expected bank_state}
    // Each row is one cycle; the expected values hold while that command is presented.
    localparam logic [18:0] VEC [0:33] = '{
        {4'd2,  ACT, 2'd1, 1'b0, 1'b0, 1'b0, 8'h00}, // R2 open bank 1
        {4'd2,  ACT, 2'd2, 1'b0, 1'b0, 1'b0, 8'h04}, // R2 open bank 2
        {4'd5,  RD,  2'd1, 1'b1, 1'b0, 1'b0, 8'h14}, // R5 read+AP bank 1
        {4'd8,  NOP, 2'd0, 1'b0, 1'b0, 1'b1, 8'h14}, // R8
        {4'd5,  RD,  2'd2, 1'b0, 1'b0, 1'b1, 8'h14}, // R5 read bank 2 cuts it
        {4'd5,  NOP, 2'd0, 1'b0, 1'b1, 1'b1, 8'h1C}, // R5 bank 1 precharging
        {4'd6,  NOP, 2'd0, 1'b0, 1'b1, 1'b1, 8'h1C}, // R6
        {4'd6,  NOP, 2'd0, 1'b0, 1'b1, 1'b1, 8'h1C}, // R6
        {4'd4,  NOP, 2'd0, 1'b0, 1'b1, 1'b1, 8'h10}, // R4 idle after T_RP
        {4'd6,  NOP, 2'd0, 1'b0, 1'b1, 1'b0, 8'h10}, // R6
        {4'd6,  NOP, 2'd0, 1'b0, 1'b1, 1'b0, 8'h10}, // R6 last beat of bank 2
        {4'd11, NOP, 2'd0, 1'b0, 1'b0, 1'b0, 8'h10}, // R11 bank 2 stays open
        {4'd2,  ACT, 2'd1, 1'b0, 1'b0, 1'b0, 8'h10}, // R2
        {4'd7,  RD,  2'd1, 1'b1, 1'b0, 1'b0, 8'h14}, // R7 read+AP bank 1
        {4'd8,  NOP, 2'd0, 1'b0, 1'b0, 1'b1, 8'h14}, // R8
        {4'd7,  WR,  2'd2, 1'b1, 1'b0, 1'b1, 8'h14}, // R7 write+AP bank 2 cuts it
        {4'd7,  NOP, 2'd0, 1'b0, 1'b0, 1'b0, 8'h1C}, // R7 in-flight beats dropped
        {4'd4,  NOP, 2'd0, 1'b0, 1'b0, 1'b0, 8'h1C}, // R4
        {4'd4,  NOP, 2'd0, 1'b0, 1'b0, 1'b0, 8'h1C}, // R4
        {4'd9,  NOP, 2'd0, 1'b0, 1'b0, 1'b0, 8'h20}, // R9 write recovery
        {4'd9,  NOP, 2'd0, 1'b0, 1'b0, 1'b0, 8'h20}, // R9
        {4'd9,  NOP, 2'd0, 1'b0, 1'b0, 1'b0, 8'h30}, // R9 then precharge
        {4'd4,  NOP, 2'd0, 1'b0, 1'b0, 1'b0, 8'h30}, // R4
        {4'd4,  NOP, 2'd0, 1'b0, 1'b0, 1'b0, 8'h30}, // R4
        {4'd4,  NOP, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00}, // R4
        {4'd2,  ACT, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00}, // R2 open bank 0
        {4'd3,  RD,  2'd0, 1'b1, 1'b0, 1'b0, 8'h01}, // R3 read+AP, NOPs only
        {4'd8,  NOP, 2'd0, 1'b0, 1'b0, 1'b1, 8'h01}, // R8
        {4'd8,  NOP, 2'd0, 1'b0, 1'b0, 1'b1, 8'h01}, // R8
        {4'd3,  NOP, 2'd0, 1'b0, 1'b1, 1'b1, 8'h01}, // R3 first beat
        {4'd3,  NOP, 2'd0, 1'b0, 1'b1, 1'b1, 8'h03}, // R3 precharge at last slot
        {4'd3,  NOP, 2'd0, 1'b0, 1'b1, 1'b0, 8'h03}, // R3
        {4'd3,  NOP, 2'd0, 1'b0, 1'b1, 1'b0, 8'h03}, // R3
        {4'd3,  NOP, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00}  // R3 done, idle
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present one command for one cycle; outputs are read 1 ns later.
    task automatic drive(input logic [1:0] c, input logic [1:0] b, input logic a);
        @(negedge clk);
        cmd_code = c;
        cmd_bank = b;
        cmd_ap   = a;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_code = NOP;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 bank_state", 32'(bank_state), 32'h00);
        check("R1 read_valid", 32'(read_valid), 0);
        check("R1 dqm_req", 32'(dqm_req), 0);
        check("R1 protocol_error", 32'(protocol_error), 0);

        for (int i = 0; i < 34; i++) begin
            logic [18:0] v;
            v = VEC[i];
            drive(v[14:13], v[12:11], v[10]);
            check($sformatf("R%0d row %0d read_valid", v[18:15], i), 32'(read_valid), 32'(v[9]));
            check($sformatf("R%0d row %0d dqm_req", v[18:15], i), 32'(dqm_req), 32'(v[8]));
            check($sformatf("R%0d row %0d bank_state", v[18:15], i), 32'(bank_state), 32'(v[7:0]));
            check($sformatf("R10 row %0d no error", i), 32'(protocol_error), 0);
        end

        // R10: ACTIVE to an idle bank is fine, to an open bank sets the sticky flag
        drive(ACT, 2'd0, 1'b0);
        drive(NOP, 2'd0, 1'b0);
        check("R10 legal activate", 32'(protocol_error), 0);
        drive(ACT, 2'd0, 1'b0);
        check("R10 not yet set", 32'(protocol_error), 0);
        drive(NOP, 2'd0, 1'b0);
        check("R10 set", 32'(protocol_error), 1);
        drive(NOP, 2'd0, 1'b0);
        drive(NOP, 2'd0, 1'b0);
        check("R10 sticky", 32'(protocol_error), 1);

        // R1: reset mid-activity clears everything
        do_reset();
        check("R1 reset bank_state", 32'(bank_state), 32'h00);
        check("R1 reset error", 32'(protocol_error), 0);

        // R7: a WRITE hides the read beat due in its own cycle and drops later ones
        drive(ACT, 2'd3, 1'b0);
        drive(ACT, 2'd0, 1'b0);
        drive(RD,  2'd3, 1'b0);
        drive(NOP, 2'd0, 1'b0);
        drive(NOP, 2'd0, 1'b0);
        drive(NOP, 2'd0, 1'b0);
        check("R7 beat before write", 32'(read_valid), 1);
        drive(WR,  2'd0, 1'b0);
        check("R7 no valid during write", 32'(read_valid), 0);
        drive(NOP, 2'd0, 1'b0);
        check("R7 no valid after write", 32'(read_valid), 0);
        drive(NOP, 2'd0, 1'b0);
        check("R11 bank 3 still open", 32'(bank_state[7:6]), 1);

        finish_run();
    end
endmodule